// File: doc/BRIEF.md
# Register-Mapped Reset Generator

This peripheral drives a bank of active-high internal reset lines from a small 32-bit register bus. Software requests a reset by writing a control word in which each 1 bit asserts one line. Line `n` is controlled by bit `n % 32` of control word `n / 32`. Most lines produce a pulse of fixed length that ends on its own. A configurable set of held lines (by default lines 12 and 56) stays asserted until a later control write carries a 0 in that bit.

Status words report the state of every line, active-low: a bit reads 0 while its line is asserted. Because every control write covers a full word, software that wants to keep a held line asserted writes back the inverted status word with its own changes applied. Line 0 is the system reset, and it also drives a dedicated output.

Top module: `rstgen_unit`

## Requirements
- R1: After the unit's own reset, every reset line and the system reset output are low and the read data is 0.
- R2: A write to control word 0 (byte offset 0x100) or word 1 (0x104) with bit b set asserts line 32*w+b at the clock edge that samples the write.
- R3: A pulse line stays high for exactly PULSE_CYC cycles (default 16) after the write edge and then drops, whatever is later written to its bit as 0.
- R4: Writing 1 to a pulse line while it is active restarts its PULSE_CYC count from the new write edge.
- R5: Held lines (12 and 56 by default) remain asserted with no time limit. They release only when a write to their control word carries a 0 in that bit. A write carrying 1 keeps them asserted.
- R6: Writing 0 to a pulse line's bit has no effect on that line, whether it is idle or active.
- R7: Reading status word 0 (0x150) or word 1 (0x154) returns, one cycle after the read strobe, bit b = 0 if line 32*w+b was active at the sampling edge and 1 otherwise. With no read strobe, the read data is 0.
- R8: Reads of the control words and of unmapped offsets return 0. Writes to any offset other than the two control words change no line.
- R9: Line 0 is the system reset. sys_rst_out follows line 0 exactly, as a registered signal, from the same write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the unit |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| rst_out | output | 64 | Active-high reset lines |
| sys_rst_out | output | 1 | System reset, mirrors line 0 |

## Verification
The bench times pulses edge by edge. A timer that is off by one gives a pulse one cycle too long or too short. A restart that fails to reload ends the pulse early. It writes zero words during an active pulse, which a design that treats the bit as level-controlled would cut short. Held lines are left asserted for far longer than a pulse, then refreshed with a 1 and released with a 0. A design that timed them out, or ignored the release, diverges there. Status reads check the inverted polarity on both words, and writes to the status and unmapped offsets catch a decoder that aliases addresses.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
   typedef enum logic [0:0] {
      LINE_PULSE = 1'b0,
      LINE_HELD  = 1'b1
   } line_kind_e;

   function automatic int unsigned word_off(input int unsigned base, input int unsigned idx);
      return base + idx * 4;
   endfunction
endpackage

// File: rtl/rstgen_regdec.sv
module rstgen_regdec #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NWORDS    = 2,
   parameter int unsigned CTRL_BASE = 'h100,
   parameter int unsigned STAT_BASE = 'h150
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output logic [NWORDS-1:0] wr_sel,
   output logic [NWORDS-1:0] rd_stat_sel
);
   import rstgen_pkg::*;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(word_off(CTRL_BASE, w));
      localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(word_off(STAT_BASE, w));
      assign wr_sel[w]      = we && (addr == CTRL_A);
      assign rd_stat_sel[w] = re && (addr == STAT_A);
   end
endmodule

// File: rtl/rstgen_line.sv
module rstgen_line #(
   parameter int unsigned           PULSE_CYC = 16,
   parameter rstgen_pkg::line_kind_e KIND     = rstgen_pkg::LINE_PULSE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   output logic line_q
);
   import rstgen_pkg::*;

   if (KIND == LINE_HELD) begin : g_held
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     line_q <= 1'b0;
         else if (wr_en) line_q <= wr_bit;
      end
   end else begin : g_pulse
      localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
         if (wr_en && wr_bit)   cnt_d = LOAD;
         else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
         else                   cnt_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            line_q <= 1'b0;
         end else begin
            cnt_q  <= cnt_d;
            line_q <= (cnt_d != '0);
         end
      end
   end
endmodule

// File: rtl/rstgen_readback.sv
module rstgen_readback #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NWORDS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NWORDS-1:0]        stat_sel,
   input  logic [NWORDS*WORD_W-1:0] line_vec,
   output logic [WORD_W-1:0]        rdata_q
);
   logic [WORD_W-1:0] term [NWORDS];
   logic [WORD_W-1:0] rdata_d;

   for (genvar w = 0; w < NWORDS; w++) begin : g_term
      assign term[w] = stat_sel[w] ? ~line_vec[w*WORD_W +: WORD_W] : '0;
   end

   always_comb begin
      rdata_d = '0;
      for (int w = 0; w < NWORDS; w++) rdata_d = rdata_d | term[w];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rdata_d;
   end
endmodule

// File: rtl/rstgen_unit.sv
module rstgen_unit #(
   parameter int unsigned     NUM_LINES = 64,
   parameter int unsigned     WORD_W    = 32,
   parameter int unsigned     ADDR_W    = 12,
   parameter int unsigned     PULSE_CYC = 16,
   parameter int unsigned     CTRL_BASE = 'h100,
   parameter int unsigned     STAT_BASE = 'h150,
   parameter int unsigned     SYS_LINE  = 0,
   parameter logic [NUM_LINES-1:0] HELD_MASK = NUM_LINES'((64'h1 << 12) | (64'h1 << 56))
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [WORD_W-1:0]    bus_wdata,
   input  logic                 bus_re,
   output logic [WORD_W-1:0]    bus_rdata,
   output logic [NUM_LINES-1:0] rst_out,
   output logic                 sys_rst_out
);
   import rstgen_pkg::*;

   localparam int unsigned NWORDS = NUM_LINES / WORD_W;

   if (NUM_LINES % WORD_W != 0) begin : g_chk_pack
      $error("NUM_LINES must be a multiple of WORD_W");
   end
   if (PULSE_CYC < 1) begin : g_chk_pulse
      $error("PULSE_CYC must be at least 1");
   end
   if (SYS_LINE >= NUM_LINES) begin : g_chk_sys
      $error("SYS_LINE out of range");
   end
   if (STAT_BASE < CTRL_BASE + 4 * NWORDS && CTRL_BASE < STAT_BASE + 4 * NWORDS) begin : g_chk_ovl
      $error("control and status windows overlap");
   end

   logic [NWORDS-1:0] wr_sel;
   logic [NWORDS-1:0] rd_stat_sel;

   rstgen_regdec #(
      .ADDR_W(ADDR_W), .NWORDS(NWORDS),
      .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
   ) u_dec (
      .addr(bus_addr), .we(bus_we), .re(bus_re),
      .wr_sel(wr_sel), .rd_stat_sel(rd_stat_sel)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      localparam line_kind_e K = HELD_MASK[n] ? LINE_HELD : LINE_PULSE;
      rstgen_line #(.PULSE_CYC(PULSE_CYC), .KIND(K)) u_line (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_sel[n / WORD_W]),
         .wr_bit(bus_wdata[n % WORD_W]),
         .line_q(rst_out[n])
      );
   end

   assign sys_rst_out = rst_out[SYS_LINE];

   rstgen_readback #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_rb (
      .clk(clk), .rst_n(rst_n),
      .stat_sel(rd_stat_sel), .line_vec(rst_out),
      .rdata_q(bus_rdata)
   );
endmodule

// File: rtl/rstgen_unit_chk.sv
module rstgen_unit_chk #(
   parameter int unsigned     NUM_LINES = 64,
   parameter int unsigned     WORD_W    = 32,
   parameter int unsigned     ADDR_W    = 12,
   parameter int unsigned     PULSE_CYC = 16,
   parameter int unsigned     CTRL_BASE = 'h100,
   parameter int unsigned     STAT_BASE = 'h150,
   parameter int unsigned     SYS_LINE  = 0,
   parameter logic [NUM_LINES-1:0] HELD_MASK = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [WORD_W-1:0]    bus_wdata,
   input logic                 bus_re,
   input logic [WORD_W-1:0]    bus_rdata,
   input logic [NUM_LINES-1:0] rst_out,
   input logic                 sys_rst_out
);
   localparam int unsigned NWORDS = NUM_LINES / WORD_W;
   localparam int unsigned RC_W   = $clog2(PULSE_CYC + 2) + 1;
   localparam logic [ADDR_W-1:0] STAT0 = ADDR_W'(STAT_BASE);
   localparam logic [ADDR_W-1:0] CTRL0 = ADDR_W'(CTRL_BASE);

   logic [NWORDS-1:0] ctrl_hit;
   for (genvar w = 0; w < NWORDS; w++) begin : g_hit
      assign ctrl_hit[w] = bus_addr == ADDR_W'(CTRL_BASE + 4 * w);
   end

   // R1: the first active edge sees every line low
   a_r1_reset_idle: assert property (@(posedge clk)
      $rose(rst_n) |-> (rst_out == '0 && !sys_rst_out && bus_rdata == '0));

   // R8: writes outside the control words raise no line
   a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && ctrl_hit == '0) |=> ((rst_out & ~$past(rst_out)) == '0));

   // R9: a system reset request reaches the dedicated output
   a_r9_sys_req: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == CTRL0 && bus_wdata[SYS_LINE % WORD_W]) |=> sys_rst_out);

   // R7: status word 0 reports inverted line state one cycle after the strobe
   a_r7_status0: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == STAT0) |=> (bus_rdata == ~$past(rst_out[WORD_W-1:0])));

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
      if (HELD_MASK[n]) begin : g_h
         // R5: a held line never drops without a control write to its word
         a_r5_held_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_out[n] && !(bus_we && ctrl_hit[n / WORD_W])) |=> rst_out[n]);
      end else begin : g_p
         logic [RC_W-1:0] run_q;
         logic            set_one;
         assign set_one = bus_we && ctrl_hit[n / WORD_W] && bus_wdata[n % WORD_W];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          run_q <= '0;
            else if (set_one)    run_q <= '0;
            else if (rst_out[n]) run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
            else                 run_q <= '0;
         end
         // R3: a pulse line never outlives its window
         a_r3_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
            rst_out[n] |-> (run_q < RC_W'(PULSE_CYC)));
         // R6: a 0 write alone never raises a pulse line
         a_r6_zero_inert: assert property (@(posedge clk) disable iff (!rst_n)
            (!rst_out[n] && !set_one) |=> !rst_out[n]);
      end
   end
endmodule

bind rstgen_unit rstgen_unit_chk #(
   .NUM_LINES(NUM_LINES), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
   .PULSE_CYC(PULSE_CYC), .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE),
   .SYS_LINE(SYS_LINE), .HELD_MASK(HELD_MASK)
) u_chk (.*);

// File: tb/rstgen_unit_bench.sv
module rstgen_unit_bench;
   localparam int P = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [63:0] rst_out;
   logic        sys_rst_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rstgen_unit u_rstgen_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .rst_out(rst_out), .sys_rst_out(sys_rst_out)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1", "lines after reset", rst_out, 64'h0);
      check("R1", "sys after reset", {63'h0, sys_rst_out}, 64'h0);
      check("R1", "rdata after reset", {32'h0, bus_rdata}, 64'h0);
      rd(12'h150, d); check("R7", "status0 idle", {32'h0, d}, 64'hFFFF_FFFF);
      rd(12'h154, d); check("R7", "status1 idle", {32'h0, d}, 64'hFFFF_FFFF);
      cyc(1);
      check("R7", "rdata without strobe", {32'h0, bus_rdata}, 64'h0);
   endtask

   task automatic t_pulse_len();
      int hi = 0;
      wr(12'h100, 32'h20);
      check("R2", "line 5 only", rst_out, 64'h20);
      for (int i = 0; i < P + 4; i++) begin
         if (rst_out[5]) hi++;
         cyc(1);
      end
      check("R3", "pulse width line 5", 64'(hi), 64'(P));
   endtask

   task automatic t_word1();
      wr(12'h104, 32'h8);
      check("R2", "word1 bit3 -> line 35", rst_out, 64'h1 << 35);
      cyc(P);
      check("R3", "line 35 ended", rst_out, 64'h0);
   endtask

   task automatic t_restart();
      wr(12'h100, 32'h80);
      cyc(9);
      wr(12'h100, 32'h80);
      cyc(P - 1);
      check("R4", "still high before new end", {63'h0, rst_out[7]}, 64'h1);
      cyc(1);
      check("R4", "low at new end", {63'h0, rst_out[7]}, 64'h0);
   endtask

   task automatic t_zero_write();
      wr(12'h100, 32'h200);
      cyc(2);
      wr(12'h100, 32'h0);
      check("R6", "zero write keeps pulse", {63'h0, rst_out[9]}, 64'h1);
      cyc(P - 5);
      wr(12'h100, 32'h0);
      check("R6", "idle lines stay low", rst_out & ~(64'h1 << 9), 64'h0);
      cyc(1);
      check("R3", "pulse ends on schedule", {63'h0, rst_out[9]}, 64'h0);
   endtask

   task automatic t_held();
      logic [31:0] d;
      wr(12'h100, 32'h1000);
      wr(12'h104, 32'h0100_0000);
      cyc(3 * P);
      check("R5", "held 12 and 56 remain", rst_out, (64'h1 << 12) | (64'h1 << 56));
      rd(12'h150, d); check("R7", "status0 with 12 held", {32'h0, d}, {32'h0, ~32'h1000});
      rd(12'h154, d); check("R7", "status1 with 56 held", {32'h0, d}, {32'h0, ~32'h0100_0000});
      wr(12'h100, 32'h1008);
      check("R5", "refresh keeps 12, pulses 3", rst_out,
            (64'h1 << 12) | (64'h1 << 56) | 64'h8);
      cyc(P);
      wr(12'h100, 32'h0);
      check("R5", "zero write releases 12", rst_out, 64'h1 << 56);
      wr(12'h104, 32'h0);
      check("R5", "zero write releases 56", rst_out, 64'h0);
   endtask

   task automatic t_sys();
      wr(12'h100, 32'h1);
      check("R9", "sys asserted", {62'h0, sys_rst_out, rst_out[0]}, 64'h3);
      cyc(P - 1);
      check("R9", "sys still high", {63'h0, sys_rst_out}, 64'h1);
      cyc(1);
      check("R9", "sys released", {62'h0, sys_rst_out, rst_out[0]}, 64'h0);
   endtask

   task automatic t_map();
      logic [31:0] d;
      wr(12'h100, 32'h1000);
      rd(12'h100, d); check("R8", "ctrl0 reads 0", {32'h0, d}, 64'h0);
      rd(12'h104, d); check("R8", "ctrl1 reads 0", {32'h0, d}, 64'h0);
      rd(12'h200, d); check("R8", "unmapped read 0", {32'h0, d}, 64'h0);
      wr(12'h108, 32'hFFFF_FFFF);
      wr(12'h150, 32'h0);
      wr(12'h101, 32'hFFFF_FFFF);
      check("R8", "stray writes ignored", rst_out, 64'h1 << 12);
      wr(12'h100, 32'h0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_pulse_len();
      t_word1();
      t_restart();
      t_zero_write();
      t_held();
      t_sys();
      t_map();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule